// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the byte-wide programming interface of a PC-style serial port. A host reaches eight byte registers through a 3-bit address with separate read and write strobes. Received characters wait in an external queue that presents a byte with a valid flag. The block pops that queue when software reads the data register. Bytes written to the data register leave on a one-cycle output strobe. Baud generation, line serialisation and modem signalling live elsewhere. Several registers therefore return fixed values that look like an idle, always-ready transmitter.

A single level interrupt covers two sources, receive data waiting and transmit holding empty. Neither source raises the line at once. Each trigger loads a per-source countdown of `DEFER_CYCLES` clock cycles. A new trigger while the countdown runs reloads it from the full value. When the countdown runs out, the source's pending bit is set only if its enable bit is still set at that moment. Deferring the interrupt stops a fast typist from keeping a receive loop in a driver spinning forever.

Top module: `sfe_serial_regs`

## Requirements
- R1: After reset, reads at offsets 0, 1, 3, 4, 6 and 7 return 0x00 and `irq` is low. Read data appears on `bus_rdata` at the clock edge that samples `bus_rd` and then holds until the next read. Offset 3 (line control) stores and returns all 8 written bits.
- R2: While line control bit 7 is 1, accesses at offsets 0 and 1 go to a divisor latch that does not exist here. Such a write sends no byte and leaves the interrupt enables unchanged. Such a read returns 0x00 and pops nothing from the receive queue.
- R3: Reading offset 0 with line control bit 7 at 0 pops one byte and returns it, or returns 0x00 when the queue is empty. The read always clears the pending receive interrupt.
- R4: Writing offset 0 with line control bit 7 at 0 raises `tx_valid` for exactly one cycle, one cycle later, with the written byte on `tx_data`. The write clears the pending transmit interrupt and starts the transmit countdown if transmit enable (interrupt-enable bit 1) is 1.
- R5: A pending bit is set exactly `DEFER_CYCLES` clock edges after the edge that sampled its trigger. A trigger that arrives while the countdown runs restarts it from the full interval.
- R6: Writing offset 1 stores bit 0 as receive enable and bit 1 as transmit enable. The other bits read back as 0. If bit 1 is 1 the transmit countdown starts; if it is 0 the countdown is cancelled and any pending transmit interrupt is cleared.
- R7: Writing offset 1 with bit 0 set while receive data is waiting starts the receive countdown. Any other write to offset 1 cancels the receive countdown and clears any pending receive interrupt.
- R8: If receive data is still waiting one cycle after a data read and receive enable is 1, the receive countdown starts on that following edge.
- R9: When receive data appears (`rx_valid` rises) while receive enable is 1, the receive countdown starts on the edge that first sees it.
- R10: Offset 2 reads 0x00 while any interrupt is pending and 0x01 otherwise. Offset 5 reads 0x60 (bit 6 transmitter empty, bit 5 holding register empty), with bit 0 also set while receive data is waiting.
- R11: Writing 0x1A (loopback bit 4 plus 0x0A) to offset 4 makes it read 0x9A. Every other write to offset 4 leaves its value unchanged.
- R12: Writes at offsets 2, 5, 6 and 7 change nothing. Offsets 6 and 7 always read 0x00.
- R13: `irq` is the OR of the receive pending bit (bit 0) and the transmit pending bit (bit 1). A clear and an expiry on the same edge leave the bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access; wins over bus_rd |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Receive queue holds a byte |
| rx_data | input | 8 | Byte at the head of the receive queue |
| rx_ready | output | 1 | Pop strobe to the receive queue |
| tx_valid | output | 1 | One-cycle strobe for an outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench measures the exact cycle on which `irq` rises after transmit-enable writes, receive-enable writes, data arrival and follow-up after a data read. A countdown that is off by one, or that starts from the wrong edge, shows up as `irq` rising one cycle early or late. It retriggers the transmit countdown halfway through. A design that queued events instead of reloading the counter would raise `irq` at the first deadline. It reads and writes offsets 0 and 1 with line control bit 7 set. A design that ignored that bit would emit a byte, pop the receive queue or change the enables. It also disables interrupt sources while they are pending, and a design that forgot to cancel would leave `irq` high or raise it later.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int NUM_SRC  = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DATA  = 3'd0,
    OFF_IEN   = 3'd1,
    OFF_IDENT = 3'd2,
    OFF_LCTL  = 3'd3,
    OFF_MCTL  = 3'd4,
    OFF_LSTAT = 3'd5,
    OFF_MSTAT = 3'd6,
    OFF_SCR   = 3'd7
  } reg_off_e;

  // interrupt source index doubles as the enable bit position
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;

  localparam int LCTL_DLAB = 7;
  localparam int LST_DR    = 0;
  localparam int LST_THRE  = 5;
  localparam int LST_TEMT  = 6;

  localparam logic [DATA_W-1:0] MCTL_KEY  = 8'h1A;
  localparam logic [DATA_W-1:0] MCTL_ECHO = 8'h9A;

  typedef struct packed {
    logic any_rd;
    logic data_rd;
    logic data_wr;
    logic ien_wr;
    logic lctl_wr;
    logic mctl_wr;
  } bus_op_t;
endpackage

// File: rtl/sfe_bus_decode.sv
`timescale 1ns/1ps
module sfe_bus_decode
  import sfe_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              dlab_i,
  output bus_op_t           op_o
);
  // write wins when both strobes are present
  always_comb begin
    op_o = '0;
    if (wr_i) begin
      case (reg_off_e'(addr_i))
        OFF_DATA: op_o.data_wr = !dlab_i;
        OFF_IEN:  op_o.ien_wr  = !dlab_i;
        OFF_LCTL: op_o.lctl_wr = 1'b1;
        OFF_MCTL: op_o.mctl_wr = 1'b1;
        default:  ;
      endcase
    end else if (rd_i) begin
      op_o.any_rd  = 1'b1;
      op_o.data_rd = (reg_off_e'(addr_i) == OFF_DATA) && !dlab_i;
    end
  end
endmodule

// File: rtl/sfe_defer_timer.sv
`timescale 1ns/1ps
module sfe_defer_timer #(
  parameter int INTERVAL = 450
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cancel_i,
  input  logic enable_i,
  output logic fire_o
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

  logic             running;
  logic [CNT_W-1:0] cnt;

  // cancel beats start, start (reload) beats expiry
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (cancel_i) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start_i) begin
      running <= 1'b1;
      cnt     <= RELOAD;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign fire_o = running && (cnt == '0) && enable_i && !cancel_i && !start_i;

  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst) (start_i && !cancel_i) |=> (running && cnt == RELOAD)) else $error("timer reload"); // R5
  AST_TMR_CANCEL: assert property (@(posedge clk) disable iff (rst) cancel_i |=> !running) else $error("timer cancel"); // R6
endmodule

// File: rtl/sfe_read_port.sv
`timescale 1ns/1ps
module sfe_read_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_i,
  input  logic [$clog2(NUM_REGS)-1:0]      addr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  vals_i,
  output logic [DATA_W-1:0]                rdata_o
);
  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= vals_i[addr_i];
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_i |=> $stable(rdata_o)) else $error("read data moved"); // R1
endmodule

// File: rtl/sfe_serial_regs.sv
`timescale 1ns/1ps
module sfe_serial_regs
  import sfe_pkg::*;
#(
  parameter int DEFER_CYCLES = 450
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);
  logic [DATA_W-1:0]  lctl, mctl;
  logic [NUM_SRC-1:0] ien, pend, pend_nx;
  logic [NUM_SRC-1:0] src_start, src_cancel, src_clear, src_fire;
  logic               rd_follow, rx_valid_q, rx_arrive, dlab;
  bus_op_t            op;
  logic [NUM_REGS-1:0][DATA_W-1:0] rd_vals;

  assign dlab      = lctl[LCTL_DLAB];
  assign rx_arrive = rx_valid && !rx_valid_q;
  assign rx_ready  = op.data_rd;

  sfe_bus_decode u_dec (
    .addr_i (bus_addr),
    .rd_i   (bus_rd),
    .wr_i   (bus_wr),
    .dlab_i (dlab),
    .op_o   (op)
  );

  // trigger, cancel and clear conditions per source
  always_comb begin
    src_start[SRC_RX]  = (op.ien_wr && bus_wdata[SRC_RX] && rx_valid)
                       || (rd_follow && ien[SRC_RX] && rx_valid)
                       || (rx_arrive && ien[SRC_RX]);
    src_cancel[SRC_RX] = op.ien_wr && !(bus_wdata[SRC_RX] && rx_valid);
    src_clear[SRC_RX]  = op.data_rd || src_cancel[SRC_RX];

    src_start[SRC_TX]  = (op.ien_wr && bus_wdata[SRC_TX]) || (op.data_wr && ien[SRC_TX]);
    src_cancel[SRC_TX] = op.ien_wr && !bus_wdata[SRC_TX];
    src_clear[SRC_TX]  = op.data_wr || src_cancel[SRC_TX];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sfe_defer_timer #(.INTERVAL(DEFER_CYCLES)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .start_i  (src_start[s]),
      .cancel_i (src_cancel[s]),
      .enable_i (ien[s]),
      .fire_o   (src_fire[s])
    );
  end

  // clear has priority over a same-cycle expiry
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_clear[s])     pend_nx[s] = 1'b0;
      else if (src_fire[s]) pend_nx[s] = 1'b1;
      else                  pend_nx[s] = pend[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lctl       <= '0;
      mctl       <= '0;
      ien        <= '0;
      pend       <= '0;
      irq        <= 1'b0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      rd_follow  <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      if (op.lctl_wr) lctl <= bus_wdata;
      if (op.mctl_wr && bus_wdata == MCTL_KEY) mctl <= MCTL_ECHO;
      if (op.ien_wr) ien <= bus_wdata[NUM_SRC-1:0];
      pend       <= pend_nx;
      irq        <= |pend_nx;
      tx_valid   <= op.data_wr;
      if (op.data_wr) tx_data <= bus_wdata;
      rd_follow  <= op.data_rd;
      rx_valid_q <= rx_valid;
    end
  end

  // synthetic read values
  always_comb begin
    rd_vals = '0;
    rd_vals[OFF_DATA]  = (!dlab && rx_valid) ? rx_data : '0;
    rd_vals[OFF_IEN]   = dlab ? '0 : DATA_W'(ien);
    rd_vals[OFF_IDENT] = (|pend) ? 8'h00 : 8'h01;
    rd_vals[OFF_LCTL]  = lctl;
    rd_vals[OFF_MCTL]  = mctl;
    rd_vals[OFF_LSTAT][LST_DR]   = rx_valid;
    rd_vals[OFF_LSTAT][LST_THRE] = 1'b1;
    rd_vals[OFF_LSTAT][LST_TEMT] = 1'b1;
  end

  sfe_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rdp (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (op.any_rd),
    .addr_i  (bus_addr),
    .vals_i  (rd_vals),
    .rdata_o (bus_rdata)
  );

  AST_TX_SEND: assert property (@(posedge clk) disable iff (rst) op.data_wr |=> (tx_valid && tx_data == $past(bus_wdata))) else $error("tx send"); // R4
  AST_DLAB_NO_TX: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == OFF_DATA && dlab) |=> !tx_valid) else $error("dlab tx"); // R2
  AST_RX_READ_CLR: assert property (@(posedge clk) disable iff (rst) op.data_rd |=> !pend[SRC_RX]) else $error("rx clear"); // R3
  AST_RX_PEND_EN: assert property (@(posedge clk) disable iff (rst) pend[SRC_RX] |-> ien[SRC_RX]) else $error("rx pend without enable"); // R7
  AST_TX_PEND_EN: assert property (@(posedge clk) disable iff (rst) pend[SRC_TX] |-> ien[SRC_TX]) else $error("tx pend without enable"); // R6
endmodule

// File: tb/sfe_serial_regs_test.sv
`timescale 1ns/1ps
module sfe_serial_regs_test;
  localparam int N = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid, irq;
  logic [7:0] tx_data;

  int checks = 0;
  int failures = 0;
  logic rd_seen = 1'b0;

  logic [7:0] rxq[$];
  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  logic [7:0] tx_exp_q[$];

  sfe_serial_regs #(.DEFER_CYCLES(N)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic void check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endfunction

  function automatic void refresh_rx();
    rx_valid = (rxq.size() != 0);
    rx_data  = (rxq.size() != 0) ? rxq[0] : 8'h00;
  endfunction

  function automatic void rx_push(logic [7:0] d);
    rxq.push_back(d);
    refresh_rx();
  endfunction

  // receive queue model: pops on the edge that samples rx_ready
  always @(posedge clk) begin
    if (rx_ready && rxq.size() != 0) begin
      void'(rxq.pop_front());
      #1;
      refresh_rx();
    end
  end

  always @(posedge clk) rd_seen <= bus_rd && !bus_wr;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_exp_q.size() == 0) check_eq("R1 read with no expectation", 1, 0);
      else check_eq(rd_tag_q.pop_front(), bus_rdata, rd_exp_q.pop_front());
    end
    if (tx_valid) begin
      if (tx_exp_q.size() == 0) check_eq("R2 R4 unexpected tx byte", tx_data, 256);
      else check_eq("R4 tx byte", tx_data, tx_exp_q.pop_front());
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    tx_exp_q.push_back(d);
    bus_write(3'd0, d);
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic irq_after(input int cycles, input logic exp, input string tag);
    repeat (cycles) @(negedge clk);
    check_eq(tag, irq, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check_eq("R1 irq after reset", irq, 0);
    check_eq("R1 tx_valid after reset", tx_valid, 0);
    bus_read(3'd0, 8'h00, "R1 data reset");
    bus_read(3'd1, 8'h00, "R1 ien reset");
    bus_read(3'd3, 8'h00, "R1 lctl reset");
    bus_read(3'd4, 8'h00, "R1 mctl reset");
    bus_read(3'd2, 8'h01, "R10 ident idle");
    bus_read(3'd5, 8'h60, "R10 lstat idle");

    // R12 ignored writes
    bus_write(3'd2, 8'hFF); bus_write(3'd7, 8'hA5);
    bus_write(3'd5, 8'hFF); bus_write(3'd6, 8'hFF);
    bus_read(3'd7, 8'h00, "R12 scratch reads zero");
    bus_read(3'd6, 8'h00, "R12 mstat reads zero");
    bus_read(3'd2, 8'h01, "R12 ident unchanged");
    bus_read(3'd5, 8'h60, "R12 lstat unchanged");
    bus_read(3'd1, 8'h00, "R12 ien unchanged");

    bus_write(3'd3, 8'h03);
    bus_read(3'd3, 8'h03, "R1 lctl readback");

    // R3 receive path, enables off
    rx_push(8'h41); rx_push(8'h42);
    bus_read(3'd5, 8'h61, "R10 lstat data ready");
    bus_read(3'd0, 8'h41, "R3 pop first");
    bus_read(3'd0, 8'h42, "R3 pop second");
    bus_read(3'd0, 8'h00, "R3 empty read zero");
    bus_read(3'd5, 8'h60, "R10 lstat drained");
    irq_after(N + 2, 1'b0, "R9 no irq with enable off");

    // R2 divisor latch gating
    bus_write(3'd3, 8'h83);
    rx_push(8'h77);
    bus_write(3'd0, 8'h55);
    bus_write(3'd1, 8'h03);
    bus_read(3'd0, 8'h00, "R2 dlab data read zero");
    bus_read(3'd1, 8'h00, "R2 dlab ien read zero");
    bus_read(3'd3, 8'h83, "R2 lctl keeps dlab");
    bus_write(3'd3, 8'h03);
    bus_read(3'd1, 8'h00, "R2 ien untouched");
    bus_read(3'd0, 8'h77, "R2 queue not popped");
    irq_after(N + 2, 1'b0, "R2 no irq from dlab writes");

    // R4 R5 transmit
    send_byte(8'h3C);
    irq_after(N + 2, 1'b0, "R4 no tx irq when disabled");
    bus_write(3'd1, 8'h02);
    irq_after(N - 1, 1'b0, "R5 tx irq not early");
    irq_after(1, 1'b1, "R5 tx irq on time");
    bus_read(3'd2, 8'h00, "R10 ident pending");
    bus_read(3'd1, 8'h02, "R6 ien readback");
    send_byte(8'hA7);
    check_eq("R4 data write clears tx pending", irq, 0);
    repeat (5) @(negedge clk);
    send_byte(8'h5A);
    irq_after(N - 1, 1'b0, "R5 retrigger restarts");
    irq_after(1, 1'b1, "R5 retrigger fires");

    // R6 cancel
    bus_write(3'd1, 8'h00);
    check_eq("R6 disable clears tx pending", irq, 0);
    bus_write(3'd1, 8'h02);
    repeat (5) @(negedge clk);
    bus_write(3'd1, 8'h00);
    irq_after(N + 3, 1'b0, "R6 cancelled countdown silent");

    // R7 R8 receive interrupts
    rx_push(8'h11); rx_push(8'h22);
    bus_write(3'd1, 8'h01);
    irq_after(N - 1, 1'b0, "R7 rx irq not early");
    irq_after(1, 1'b1, "R7 rx irq on time");
    bus_read(3'd2, 8'h00, "R13 ident shows rx pending");
    bus_read(3'd0, 8'h11, "R3 pop with irq");
    check_eq("R3 read clears rx pending", irq, 0);
    irq_after(N, 1'b0, "R8 follow-up not early");
    irq_after(1, 1'b1, "R8 follow-up fires");
    bus_write(3'd1, 8'h00);
    check_eq("R7 disable clears rx pending", irq, 0);
    irq_after(N + 3, 1'b0, "R7 cancelled rx silent");
    bus_read(3'd0, 8'h22, "R3 drain");
    bus_write(3'd1, 8'h01);
    irq_after(N + 3, 1'b0, "R7 no start without data");

    // R9 arrival
    rx_push(8'h33);
    irq_after(N, 1'b0, "R9 arrival not early");
    irq_after(1, 1'b1, "R9 arrival fires");
    bus_read(3'd0, 8'h33, "R3 pop arrival byte");
    check_eq("R3 clear after arrival", irq, 0);
    irq_after(N + 3, 1'b0, "R8 no follow-up when empty");

    // R11 modem control
    bus_write(3'd4, 8'h1B);
    bus_read(3'd4, 8'h00, "R11 other value ignored");
    bus_write(3'd4, 8'h1A);
    bus_read(3'd4, 8'h9A, "R11 loopback key");
    bus_write(3'd4, 8'h00);
    bus_read(3'd4, 8'h9A, "R11 value kept");

    bus_write(3'd1, 8'hFC);
    bus_read(3'd1, 8'h00, "R6 upper bits dropped");
    bus_write(3'd1, 8'h00);

    repeat (3) @(negedge clk);
    check_eq("R4 all tx bytes seen", tx_exp_q.size(), 0);
    check_eq("R1 all reads seen", rd_exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule